// File: doc/BRIEF.md
# Split-Read Interrupt Status Register

This block keeps a 32-bit set of sticky event flags and a 32-bit enable mask. It drives one active-low attention line to the host. A single-cycle pulse on an event input sets the matching flag. The host reads the flags as two 16-bit halves, and each read clears the flags in the half that was read. The attention line goes low when any flag is set whose mask bit is also set.

One read of either half raises the line again. After that, the line stays quiet until the host has read both halves, which makes sure a full 32-bit snapshot has been taken. Once both halves have been read, the line falls again on the following cycle if any enabled flag is still set. Typical use is a host handler that reads the lower half and then the upper half, and returns only when the line stays high.

Top module: `irq_split_status`

## Requirements
- R1: After reset, irq_no is 1, all 32 flags are 0 and all 32 mask bits are 0.
- R2: An event_i[i] pulse sets flag i at the next clock edge. The mask value does not affect this.
- R3: In the same cycle as the strobe, rd_data_o shows flags [15:0] while rd_lo_i is 1 and flags [31:16] while only rd_hi_i is 1. When both strobes are 1 it shows the lower half. When neither strobe is 1 it shows 0. The value shown is the value before any clear from that read.
- R4: At the edge that samples rd_lo_i (or rd_hi_i), every flag in the lower (or upper) half is cleared, except a flag whose event_i bit is 1 in that same cycle. Such a flag stays set.
- R5: mask_we_i loads mask_wdata_i into the mask at the next edge. A mask bit of 1 enables the matching flag. A flag whose mask bit is 0 never causes irq_no to go low.
- R6: When the line is armed and high, and at least one flag is set with its mask bit set, irq_no goes low at the next edge.
- R7: A read of either half while irq_no is low makes irq_no 1 after that edge.
- R8: Assertion clears the record of which halves have been read. A read sampled at the same edge as the assertion does not count. irq_no cannot go low again until each half has been read at least once since the assertion. The edge after the read that completes the pair, irq_no goes low if an enabled flag is still set.
- R9: The line is armed out of reset, so the first enabled flag asserts irq_no without any prior read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | 32 | Single-cycle set pulses, one per flag |
| mask_we_i | input | 1 | Mask write enable |
| mask_wdata_i | input | 32 | New mask value |
| rd_lo_i | input | 1 | Read strobe for flags [15:0] |
| rd_hi_i | input | 1 | Read strobe for flags [31:16] |
| rd_data_o | output | 16 | Read data for the selected half |
| irq_no | output | 1 | Attention line, active low |

## Verification
Read data is combinational, so the bench compares rd_data_o a short time after it drives the strobes at the falling edge, in the same cycle. Flag updates, mask loads and changes of irq_no each take exactly one edge. The bench samples irq_no one time unit after each rising edge, against a model updated from the inputs of the cycle just ended. Two timings follow from this: a mask write reaches irq_no two edges after it is driven, and the read that completes the pair lets irq_no fall at the second edge after it. The directed cases check exactly those edges.

// File: rtl/irq_split_pkg.sv
package irq_split_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } half_rd_t;

  localparam int NUM_HALVES = 2;
endpackage

// File: rtl/isr_flag_half.sv
module isr_flag_half #(
  parameter int HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] set_i,
  input  logic              clr_i,
  output logic [HALF_W-1:0] flags_o
);
  logic [HALF_W-1:0] flags_q;

  // a new event wins over a clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= set_i | (flags_q & {HALF_W{~clr_i}});
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/isr_mask_reg.sv
module isr_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/isr_rearm_ctrl.sv
module isr_rearm_ctrl
  import irq_split_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pending_i,
  input  half_rd_t rd_i,
  output logic     irq_o
);
  logic     irq_q;
  half_rd_t seen_q;
  logic     armed, fire;

  assign armed = seen_q.lo & seen_q.hi;
  assign fire  = ~irq_q & armed & pending_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      seen_q <= '{hi: 1'b1, lo: 1'b1};
    end else if (fire) begin
      irq_q  <= 1'b1;
      seen_q <= '0;
    end else begin
      if (irq_q && (rd_i.lo || rd_i.hi)) irq_q <= 1'b0;
      seen_q.lo <= seen_q.lo | rd_i.lo;
      seen_q.hi <= seen_q.hi | rd_i.hi;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_split_status.sv
module irq_split_status
  import irq_split_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int STAT_W = NUM_HALVES * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] event_i,
  input  logic              mask_we_i,
  input  logic [STAT_W-1:0] mask_wdata_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  output logic [HALF_W-1:0] rd_data_o,
  output logic              irq_no
);
  half_rd_t                rd_s;
  logic [NUM_HALVES-1:0]   rd_vec;
  logic [STAT_W-1:0]       status_q;
  logic [STAT_W-1:0]       mask_q;
  logic                    pending;
  logic                    irq;

  assign rd_s   = '{hi: rd_hi_i, lo: rd_lo_i};
  assign rd_vec = {rd_hi_i, rd_lo_i};

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    isr_flag_half #(.HALF_W(HALF_W)) u_flags (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (event_i[h*HALF_W +: HALF_W]),
      .clr_i  (rd_vec[h]),
      .flags_o(status_q[h*HALF_W +: HALF_W])
    );
  end

  isr_mask_reg #(.W(STAT_W)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_we_i),
    .wdata_i(mask_wdata_i),
    .mask_o (mask_q)
  );

  assign pending = |(status_q & mask_q);

  isr_rearm_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pending_i(pending),
    .rd_i     (rd_s),
    .irq_o    (irq)
  );

  // lower half wins when both strobes are high
  always_comb begin
    if (rd_lo_i)      rd_data_o = status_q[HALF_W-1:0];
    else if (rd_hi_i) rd_data_o = status_q[STAT_W-1:HALF_W];
    else              rd_data_o = '0;
  end

  assign irq_no = ~irq;
endmodule

// File: rtl/irq_split_status_chk.sv
module irq_split_status_chk #(
  parameter int HALF_W = 16,
  localparam int STAT_W = 2 * HALF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STAT_W-1:0] event_i,
  input logic              rd_lo_i,
  input logic              rd_hi_i,
  input logic              irq_no,
  input logic [STAT_W-1:0] status_q,
  input logic [STAT_W-1:0] mask_q
);
  logic irq_prev, seen_lo_c, seen_hi_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_prev  <= 1'b1;
      seen_lo_c <= 1'b1;
      seen_hi_c <= 1'b1;
    end else begin
      irq_prev <= irq_no;
      if (!irq_no && irq_prev) begin
        seen_lo_c <= rd_lo_i;
        seen_hi_c <= rd_hi_i;
      end else begin
        seen_lo_c <= seen_lo_c | rd_lo_i;
        seen_hi_c <= seen_hi_c | rd_hi_i;
      end
    end
  end

  a_r2_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(event_i)) == $past(event_i)));

  a_r4_lo_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> (status_q[HALF_W-1:0] == $past(event_i[HALF_W-1:0])));

  a_r4_hi_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi_i |=> (status_q[STAT_W-1:HALF_W] == $past(event_i[STAT_W-1:HALF_W])));

  a_r5_fall_needs_enabled_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> $past(|(status_q & mask_q)));

  a_r7_read_drops_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && (rd_lo_i || rd_hi_i)) |=> irq_no);

  a_r8_both_halves_before_reassert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> $past(seen_lo_c && seen_hi_c));
endmodule

bind irq_split_status irq_split_status_chk #(.HALF_W(HALF_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .event_i (event_i),
  .rd_lo_i (rd_lo_i),
  .rd_hi_i (rd_hi_i),
  .irq_no  (irq_no),
  .status_q(status_q),
  .mask_q  (mask_q)
);

// File: tb/irq_split_status_tb.sv
module irq_split_status_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_W = 16;
  localparam int W = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [W-1:0]  event_i = '0;
  logic          mask_we_i = 1'b0;
  logic [W-1:0]  mask_wdata_i = '0;
  logic          rd_lo_i = 1'b0;
  logic          rd_hi_i = 1'b0;
  logic [HALF_W-1:0] rd_data_o;
  logic          irq_no;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] m_status = '0;
  logic [W-1:0] m_mask = '0;
  logic         m_irq = 1'b0;
  logic         m_slo = 1'b1;
  logic         m_shi = 1'b1;
  logic [HALF_W-1:0] last_rd;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_split_status u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .event_i     (event_i),
    .mask_we_i   (mask_we_i),
    .mask_wdata_i(mask_wdata_i),
    .rd_lo_i     (rd_lo_i),
    .rd_hi_i     (rd_hi_i),
    .rd_data_o   (rd_data_o),
    .irq_no      (irq_no)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [HALF_W-1:0] exp_rd(input logic [W-1:0] st, input bit lo,
                                                input bit hi);
    if (lo)      return st[HALF_W-1:0];
    else if (hi) return st[W-1:HALF_W];
    else         return '0;
  endfunction

  // called just after a falling edge; returns just after the next falling edge
  task automatic drive(input logic [W-1:0] ev, input bit rlo, input bit rhi,
                       input bit mwe, input logic [W-1:0] mwd, input string tag);
    logic [W-1:0] clr, n_status, n_mask;
    logic n_irq, n_slo, n_shi, fire;
    event_i = ev; rd_lo_i = rlo; rd_hi_i = rhi;
    mask_we_i = mwe; mask_wdata_i = mwd;
    #1;
    last_rd = rd_data_o;
    check(rd_data_o == exp_rd(m_status, rlo, rhi), "R3", W'(rd_data_o),
          W'(exp_rd(m_status, rlo, rhi)));
    clr      = {{HALF_W{rhi}}, {HALF_W{rlo}}};
    n_status = ev | (m_status & ~clr);
    n_mask   = mwe ? mwd : m_mask;
    fire     = !m_irq && m_slo && m_shi && (|(m_status & m_mask));
    if (fire) begin
      n_irq = 1'b1; n_slo = 1'b0; n_shi = 1'b0;
    end else begin
      n_irq = m_irq && !(rlo || rhi);
      n_slo = m_slo | rlo;
      n_shi = m_shi | rhi;
    end
    @(posedge clk_i);
    #1;
    m_status = n_status; m_mask = n_mask; m_irq = n_irq; m_slo = n_slo; m_shi = n_shi;
    check(irq_no == !m_irq, tag, W'(irq_no), W'(!m_irq));
    @(negedge clk_i);
    event_i = '0; rd_lo_i = 1'b0; rd_hi_i = 1'b0; mask_we_i = 1'b0;
  endtask

  task automatic idle(input string tag);
    drive('0, 1'b0, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL R1: watchdog expired, actual running expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    #(CLK_PERIOD * 3);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1: reset state
    check(irq_no == 1'b1, "R1", W'(irq_no), W'(1));
    drive('0, 1'b1, 1'b0, 1'b0, '0, "R1");
    check(last_rd == '0, "R1", W'(last_rd), '0);
    drive('0, 1'b0, 1'b1, 1'b0, '0, "R1");
    check(last_rd == '0, "R1", W'(last_rd), '0);

    // R5: flags set while mask is all zero
    drive(32'h0010_0008, 1'b0, 1'b0, 1'b0, '0, "R5");
    idle("R5");
    check(irq_no == 1'b1, "R5", W'(irq_no), W'(1));
    // enable bit 3 only; line falls one edge after the mask lands (R6, R9)
    drive('0, 1'b0, 1'b0, 1'b1, 32'h0000_0008, "R6");
    check(irq_no == 1'b1, "R6", W'(irq_no), W'(1));
    idle("R6");
    check(irq_no == 1'b0, "R9", W'(irq_no), W'(0));

    // R7: upper read drops the line; bit 20 is in the read data (R2)
    drive('0, 1'b0, 1'b1, 1'b0, '0, "R7");
    check(last_rd == 16'h0010, "R2", W'(last_rd), W'(16'h0010));
    check(irq_no == 1'b1, "R7", W'(irq_no), W'(1));
    // R8: lower half not yet read, bit 3 still enabled and set
    idle("R8"); idle("R8"); idle("R8");
    check(irq_no == 1'b1, "R8", W'(irq_no), W'(1));

    // R4: lower read with a fresh event on bit 3 keeps it set
    drive(32'h0000_0008, 1'b1, 1'b0, 1'b0, '0, "R4");
    check(last_rd == 16'h0008, "R2", W'(last_rd), W'(16'h0008));
    check(irq_no == 1'b1, "R8", W'(irq_no), W'(1));
    idle("R8");
    check(irq_no == 1'b0, "R8", W'(irq_no), W'(0));

    // R3: both strobes show the lower half and clear both halves
    drive('0, 1'b1, 1'b1, 1'b0, '0, "R7");
    check(last_rd == 16'h0008, "R3", W'(last_rd), W'(16'h0008));
    idle("R6");
    check(irq_no == 1'b1, "R4", W'(irq_no), W'(1));
    drive('0, 1'b1, 1'b0, 1'b0, '0, "R4");
    check(last_rd == '0, "R4", W'(last_rd), '0);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] ev;
      ev = $urandom & $urandom & $urandom & $urandom;
      drive(ev, ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 25) == 0,
            $urandom & $urandom, "R6");
    end
    finish_run();
  end
endmodule